// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer execute unit of a RISC-style datapath. Each cycle it may accept one operation: two 32-bit register operands, a 16-bit immediate with a flag that selects it as the second operand, a 5-bit constant shift count and a 4-bit operation code. It returns the result one clock later, registered, together with a destination write enable and a one-cycle overflow-exception strobe.

Arithmetic is two's complement throughout. Add and subtract each come in two forms. The trapping form raises the exception strobe on signed overflow and withholds the write. The wrapping form always writes the truncated result. Set-less-than also comes in two forms: one compares as signed, the other as unsigned. The unit also performs four bitwise operations and three kinds of shift, each with a constant count or a count taken from a register. A small front end widens the immediate: it sign-extends for arithmetic and compare operations and zero-extends for bitwise ones. The block keeps no overflow flag between operations.

Top module: `int_alu`

## Requirements
- R1: After synchronous active-high reset `out_valid`, `wr_en`, `ovf_trap` and `result` are 0. Each accepted operation (`in_valid`=1) produces `out_valid`=1 on the next clock. A cycle with `in_valid`=0 gives `out_valid`, `wr_en` and `ovf_trap` all 0 on the next clock.
- R2: ADD (op 0), ADDU (op 1), SUB (op 2) and SUBU (op 3) return the low 32 bits of a+b or a-b. `a` is `rs_val`. `b` is the second operand, which is `rt_val` or the widened immediate.
- R3: ADD signals overflow only when both operands have the same sign and the sum's sign differs from it. SUB signals overflow only when the operand signs differ and the difference's sign differs from the sign of `a`. Overflow raises `ovf_trap` for exactly that result cycle.
- R4: When `ovf_trap` is 1, `wr_en` is 0 and `result` still shows the wrapped value. ADDU, SUBU and all non-arithmetic operations never raise `ovf_trap`, and every valid result that does not trap has `wr_en`=1.
- R5: SLT (op 4) compares as signed and SLTU (op 5) compares as unsigned. Each returns 1 when a<b and 0 otherwise, with bits 31..1 at zero. For a=0xFFFFFFFF and b=1, SLT gives 1 and SLTU gives 0.
- R6: AND (op 6), OR (op 7), NOR (op 8) and XOR (op 9) act bit by bit on a and b.
- R7: SLL (op 10) and SRL (op 11) shift `rt_val` by `shamt` and fill the vacated positions with zeros. SRA (op 12) shifts right and fills with copies of bit 31.
- R8: SLLV (op 13), SRLV (op 14) and SRAV (op 15) shift `rt_val` by `rs_val[4:0]`. Bits 31..5 of `rs_val` and the whole of `shamt` have no effect on these operations.
- R9: With `use_imm`=1, ops 0 to 5 use `imm` sign-extended to 32 bits as b, and ops 6 to 9 use `imm` zero-extended. Shifts ignore `use_imm` and `imm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see requirements) |
| rs_val | input | 32 | First operand; variable shift count in bits 4..0 |
| rt_val | input | 32 | Second register operand; value shifted by shifts |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Select widened immediate as second operand |
| shamt | input | 5 | Constant shift count |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| ovf_trap | output | 1 | Overflow exception strobe |

## Verification
The overflow exception and the result write fall in the same output cycle, and they must exclude each other. The bench provokes the collision by driving trapping adds and subtracts at the signed range limits: 0x7FFFFFFF+1, 0x80000000-1, and the negative-plus-negative and mixed-sign subtract cases. It then runs the same operands through the wrapping forms. In each of these cycles the bench checks that the wrapped sum is shown, that the strobe is set, and that the write enable is clear. A behavioural model built on 64-bit integer arithmetic supplies the expected values, and the same model judges a long run of pseudo-random operations across all sixteen codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_SLT  = 4'd4,
        OP_SLTU = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_NOR  = 4'd8,
        OP_XOR  = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_SLLV = 4'd13,
        OP_SRLV = 4'd14,
        OP_SRAV = 4'd15
    } alu_op_e;

    // status that travels with the result into the output register
    typedef struct packed {
        logic valid;
        logic wr;
        logic trap;
    } alu_stat_t;

    function automatic logic is_shift(input alu_op_e o);
        return (o == OP_SLL)  || (o == OP_SRL)  || (o == OP_SRA) ||
               (o == OP_SLLV) || (o == OP_SRLV) || (o == OP_SRAV);
    endfunction

    function automatic logic is_bitwise(input alu_op_e o);
        return (o == OP_AND) || (o == OP_OR) || (o == OP_NOR) || (o == OP_XOR);
    endfunction

    function automatic logic is_subtract(input alu_op_e o);
        return (o == OP_SUB) || (o == OP_SUBU) || (o == OP_SLT) || (o == OP_SLTU);
    endfunction

    function automatic logic traps(input alu_op_e o);
        return (o == OP_ADD) || (o == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_opnd_mux.sv
module alu_opnd_mux
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     rt_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output logic [W-1:0]     opnd_b
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_sx;
    logic [W-1:0] imm_zx;

    assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign imm_zx = {{EXT_W{1'b0}}, imm};

    always_comb begin
        if (!use_imm || is_shift(op)) begin
            opnd_b = rt_val;
        end else if (is_bitwise(op)) begin
            opnd_b = imm_zx;
        end else begin
            opnd_b = imm_sx;
        end
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);
    logic         sub;
    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic         ovf_raw;

    assign sub   = is_subtract(op);
    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign sum   = wide[W-1:0];

    // same sign going in, different sign coming out
    assign ovf_raw = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    assign ovf     = ovf_raw && traps(op);

    assign lt_s = sum[W-1] ^ ovf_raw;
    assign lt_u = ~wide[W];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e              op,
    input  logic [W-1:0]         val,
    input  logic [$clog2(W)-1:0] amt_const,
    input  logic [W-1:0]         amt_reg,
    output logic [W-1:0]         shifted
);
    localparam int SH = $clog2(W);

    logic          left;
    logic          fill;
    logic          var_amt;
    logic [SH-1:0] amt;
    logic [W-1:0]  stg [0:SH];

    assign left    = (op == OP_SLL) || (op == OP_SLLV);
    assign fill    = ((op == OP_SRA) || (op == OP_SRAV)) && val[W-1];
    assign var_amt = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
    assign amt     = var_amt ? amt_reg[SH-1:0] : amt_const;

    assign stg[0] = val;

    for (genvar i = 0; i < SH; i++) begin : g_stage
        localparam int K = 1 << i;
        always_comb begin
            if (!amt[i]) begin
                stg[i+1] = stg[i];
            end else if (left) begin
                stg[i+1] = {stg[i][W-1-K:0], {K{1'b0}}};
            end else begin
                stg[i+1] = {{K{fill}}, stg[i][W-1:K]};
            end
        end
    end

    assign shifted = stg[SH];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16,
    parameter int SH_W  = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [W-1:0]     rs_val,
    input  logic [W-1:0]     rt_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic [SH_W-1:0]  shamt,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             wr_en,
    output logic             ovf_trap
);
    alu_op_e      op_e;
    logic [W-1:0] opnd_b;
    logic [W-1:0] sum;
    logic         ovf;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] sh_y;
    logic [W-1:0] lg_y;
    logic [W-1:0] res_d;
    alu_stat_t    stat_d;
    alu_stat_t    stat_q;
    logic [W-1:0] res_q;

    assign op_e = alu_op_e'(op);

    alu_opnd_mux #(.W(W), .IMM_W(IMM_W)) u_mux (
        .op(op_e), .rt_val(rt_val), .imm(imm), .use_imm(use_imm), .opnd_b(opnd_b)
    );

    alu_addsub #(.W(W)) u_add (
        .op(op_e), .a(rs_val), .b(opnd_b), .sum(sum),
        .ovf(ovf), .lt_s(lt_s), .lt_u(lt_u)
    );

    alu_shifter #(.W(W)) u_sh (
        .op(op_e), .val(rt_val), .amt_const(shamt), .amt_reg(rs_val), .shifted(sh_y)
    );

    alu_logic #(.W(W)) u_lg (
        .op(op_e), .a(rs_val), .b(opnd_b), .y(lg_y)
    );

    always_comb begin
        if (is_shift(op_e)) begin
            res_d = sh_y;
        end else if (is_bitwise(op_e)) begin
            res_d = lg_y;
        end else if (op_e == OP_SLT) begin
            res_d = {{(W-1){1'b0}}, lt_s};
        end else if (op_e == OP_SLTU) begin
            res_d = {{(W-1){1'b0}}, lt_u};
        end else begin
            res_d = sum;
        end
    end

    always_comb begin
        stat_d.valid = in_valid;
        stat_d.trap  = in_valid && ovf;
        stat_d.wr    = in_valid && !ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            res_q  <= '0;
        end else begin
            stat_q <= stat_d;
            res_q  <= res_d;
        end
    end

    assign out_valid = stat_q.valid;
    assign wr_en     = stat_q.wr;
    assign ovf_trap  = stat_q.trap;
    assign result    = res_q;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [3:0]   op,
    input logic         use_imm,
    input logic [W-1:0] rs_val,
    input logic [W-1:0] rt_val,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic         ovf_trap
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !ovf_trap));

    a_r4_trap_blocks_write: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> (out_valid && !wr_en));

    a_r4_wrap_no_trap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(op == OP_ADD || op == OP_SUB)) |=> (!ovf_trap && wr_en));

    a_r3_mixed_add_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_imm && op == OP_ADD && rs_val[W-1] != rt_val[W-1]) |=> !ovf_trap);

    a_r3_same_sub_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_imm && op == OP_SUB && rs_val[W-1] == rt_val[W-1]) |=> !ovf_trap);

    a_r5_compare_boolean: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_SLT || op == OP_SLTU)) |=> (result[W-1:1] == '0));
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .ovf_trap(ovf_trap)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm;
    logic        use_imm;
    logic [4:0]  shamt;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        ovf_trap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    int_alu u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rs_val(rs_val),
        .rt_val(rt_val), .imm(imm), .use_imm(use_imm), .shamt(shamt),
        .out_valid(out_valid), .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap)
    );

    function automatic string tag_of(input logic [3:0] o);
        if (o <= 4'd3) return "R2/R3";
        if (o <= 4'd5) return "R5";
        if (o <= 4'd9) return "R6";
        if (o <= 4'd12) return "R7";
        return "R8";
    endfunction

    // behavioural reference on 64-bit integers
    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b_reg,
                         input logic [15:0] im, input logic ui, input logic [4:0] sh,
                         output logic [31:0] res, output logic trap);
        logic [31:0] b;
        longint s;
        trap = 1'b0;
        b = b_reg;
        if (ui && o <= 4'd5) b = 32'($signed(im));
        else if (ui && o <= 4'd9) b = {16'h0, im};
        case (o)
            4'd0, 4'd1: begin
                s = longint'($signed(a)) + longint'($signed(b));
                res = s[31:0];
                trap = (o == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                s = longint'($signed(a)) - longint'($signed(b));
                res = s[31:0];
                trap = (o == 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd4: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd5: res = (a < b) ? 32'd1 : 32'd0;
            4'd6: res = a & b;
            4'd7: res = a | b;
            4'd8: res = ~(a | b);
            4'd9: res = a ^ b;
            4'd10: res = b_reg << sh;
            4'd11: res = b_reg >> sh;
            4'd12: res = $unsigned($signed(b_reg) >>> sh);
            4'd13: res = b_reg << a[4:0];
            4'd14: res = b_reg >> a[4:0];
            default: res = $unsigned($signed(b_reg) >>> a[4:0]);
        endcase
    endtask

    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic ui, input logic [4:0] sh,
                       input string tag);
        logic [31:0] er;
        logic et;
        model(o, a, b, im, ui, sh, er, et);
        @(negedge clk);
        in_valid = 1'b1; op = o; rs_val = a; rt_val = b; imm = im; use_imm = ui; shamt = sh;
        @(posedge clk);
        #2;
        checks++;
        if (out_valid !== 1'b1 || result !== er || ovf_trap !== et || wr_en !== !et) begin
            errors++;
            $display("FAIL %s op=%0d: got v=%b res=%h trap=%b wr=%b, expected v=1 res=%h trap=%b wr=%b",
                     tag, o, out_valid, result, ovf_trap, wr_en, er, et, !et);
        end
    endtask

    task automatic idle_check;
        @(negedge clk);
        in_valid = 1'b0; op = 4'd0; rs_val = 32'h7FFF_FFFF; rt_val = 32'd1;
        @(posedge clk);
        #2;
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || ovf_trap !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle: got v=%b wr=%b trap=%b, expected 0 0 0",
                     out_valid, wr_en, ovf_trap);
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 4'd0; rs_val = '0; rt_val = '0;
        imm = '0; use_imm = 1'b0; shamt = '0;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || ovf_trap !== 1'b0 || result !== 32'd0) begin
            errors++;
            $display("FAIL R1 reset: got v=%b wr=%b trap=%b res=%h, expected all zero",
                     out_valid, wr_en, ovf_trap, result);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2 plain arithmetic
        run(4'd0, 32'd5, 32'd6, 16'h0, 1'b0, 5'd0, "R2");
        run(4'd2, 32'd5, 32'd6, 16'h0, 1'b0, 5'd0, "R2");
        // R3 / R4 overflow at the range limits, trapping and wrapping
        run(4'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, "R3");
        run(4'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, "R4");
        run(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, "R3");
        run(4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, "R3");
        run(4'd2, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 5'd0, "R3");
        run(4'd3, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 5'd0, "R4");
        run(4'd2, 32'd0, 32'h8000_0000, 16'h0, 1'b0, 5'd0, "R3");
        run(4'd2, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 5'd0, "R3");
        // R5 compare of all-ones against one
        run(4'd4, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, "R5");
        run(4'd5, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, "R5");
        run(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 5'd0, "R5");
        // R6 bitwise
        run(4'd8, 32'hF0F0_0000, 32'h0F00_00FF, 16'h0, 1'b0, 5'd0, "R6");
        run(4'd9, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 1'b0, 5'd0, "R6");
        // R7 constant shifts
        run(4'd10, 32'h0, 32'h8000_0001, 16'h0, 1'b0, 5'd31, "R7");
        run(4'd11, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd4, "R7");
        run(4'd12, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd4, "R7");
        run(4'd12, 32'h0, 32'h0000_00AD, 16'h0, 1'b0, 5'd3, "R7");
        // R8 variable shifts: upper amount bits and shamt ignored
        run(4'd13, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0, 1'b0, 5'd7, "R8");
        run(4'd15, 32'h0000_0120, 32'hF000_0000, 16'h0, 1'b0, 5'd9, "R8");
        run(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0, "R8");
        // R9 immediate widening
        run(4'd0, 32'd10, 32'd0, 16'hFFFF, 1'b1, 5'd0, "R9");
        run(4'd5, 32'd5, 32'd0, 16'hFFFF, 1'b1, 5'd0, "R9");
        run(4'd7, 32'h0, 32'hFFFF_FFFF, 16'h8001, 1'b1, 5'd0, "R9");
        run(4'd10, 32'h0, 32'h0000_0003, 16'hFFFF, 1'b1, 5'd2, "R9");
        run(4'd0, 32'h8000_0000, 32'd0, 16'h8000, 1'b1, 5'd0, "R9");
        // R1 idle cycle after a trapping op
        run(4'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 5'd0, "R3");
        idle_check();

        for (int i = 0; i < 600; i++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 15));
            run(o, (i % 4 == 0) ? {$urandom_range(0, 1) == 1 ? 2'b10 : 2'b01, 30'($urandom)} : $urandom,
                $urandom, 16'($urandom), 1'($urandom_range(0, 1)), 5'($urandom), tag_of(o));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule